// File: doc/BRIEF.md
# Tearing-Effect Synchronized Transmit Gate

This block sits in front of a display byte shifter and decides when each queued transmit command may start. Each command arrives over a valid/ready handshake with a two-bit synchronization mode and a byte count. An unsynchronized command is released at once. A synchronized command is held until the chosen edge appears on the panel's tearing-effect (TE) line. The gate then waits a programmed delay and releases the command with a one-cycle `go` pulse. The pulse carries the byte count to the shifter.

The delay is counted in ticks of a cascaded power-of-two timer. The first stage divides the core clock by 2^`ratio0_i`. The second stage divides the first by 2^`ratio1_i`. The delay lasts `ttew_i` second-stage ticks. Software normally requests synchronization only on the first pixel-data command of a new frame. Later chunks of the same frame and plain register commands go out unsynchronized.

Top module: `te_tx_gate`

## Requirements
- R1: After reset, `go_o` is low and `cmd_ready_o` is high.
- R2: The sync field uses these codes: 0 = none, 1 = TE rising edge, 2 = TE falling edge. A command with code 0 is accepted on a clock edge where valid and ready are both high. `go_o` is then high during the next cycle, and TE is not examined.
- R3: Sync code 3 is reserved and behaves exactly like code 0.
- R4: A code 1 command waits for a low-to-high TE transition. High-to-low transitions do not release it.
- R5: A code 2 command waits for a high-to-low TE transition. Low-to-high transitions do not release it.
- R6: Only TE transitions that occur after the command is accepted are counted. A TE level that was already reached before acceptance does not release the command.
- R7: TE passes through a two-flop synchronizer. The time from a TE change to the cycle in which `go_o` is high is 3 + `ttew`·2^(`ratio0`+`ratio1`) rising clock edges.
- R8: A `ttew` of 0 releases the command with no added delay, giving a 3-edge latency.
- R9: `go_o` is a single-cycle pulse. While it is high, `go_len_o` equals the accepted byte count; the 19-bit count covers up to 0x40000 bytes. `cmd_ready_o` returns high in the cycle after the pulse.
- R10: `cmd_ready_o` stays low from acceptance until the `go_o` pulse, so no second command is taken while one is waiting.
- R11: `ratio0_i`, `ratio1_i` and `ttew_i` are sampled at acceptance. Changing them while a command waits does not alter its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| te_i | input | 1 | Asynchronous tearing-effect line from the panel |
| cmd_valid_i | input | 1 | Transmit command offered |
| cmd_ready_o | output | 1 | Gate can take a command |
| cmd_sync_i | input | 2 | Sync mode: 0 none, 1 rising, 2 falling, 3 reserved |
| cmd_len_i | input | 19 | Byte count of the command |
| ratio0_i | input | 4 | First-stage divide exponent |
| ratio1_i | input | 4 | Second-stage divide exponent |
| ttew_i | input | 16 | Delay in second-stage ticks after the edge |
| go_o | output | 1 | One-cycle start pulse to the shifter |
| go_len_o | output | 19 | Byte count of the released command |

## Verification
The assertions check the handshake on every cycle. They confirm that `go_o` never lasts more than one cycle and never coincides with ready. They also confirm that an unsynchronized or reserved-code command fires on the next cycle while a synchronized one does not, and that ready returns right after the pulse. Three things depend on what TE did and when, so only the bench scenarios can show them. These are the edge polarity selection, the rejection of transitions that happened before acceptance, and the exact latency of 3 plus the scaled delay, including the case where settings change mid-wait.

// File: rtl/te_gate_pkg.sv
package te_gate_pkg;
    parameter int unsigned RATIO_W = 4;
    parameter int unsigned TTEW_W  = 16;
    parameter int unsigned LEN_W   = 19;

    typedef enum logic [1:0] {
        SYNC_NONE = 2'd0,
        SYNC_RISE = 2'd1,
        SYNC_FALL = 2'd2,
        SYNC_RSVD = 2'd3
    } sync_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EDGE,
        ST_DELAY,
        ST_FIRE
    } gate_state_e;
endpackage

// File: rtl/te_edge_det.sv
module te_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic te_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } det_t;

    det_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = te_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise_o = r_q.s2 & ~r_q.prev;
    assign fall_o = ~r_q.s2 & r_q.prev;
endmodule

// File: rtl/te_tick_gen.sv
module te_tick_gen #(
    parameter int unsigned RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [RATIO_W-1:0] ratio0_i,
    input  logic [RATIO_W-1:0] ratio1_i,
    output logic               tick_o
);
    localparam int unsigned CNT_W = 1 << RATIO_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt0;
        logic [CNT_W-1:0] cnt1;
    } tick_t;

    tick_t r_d, r_q;
    logic [CNT_W-1:0] lim0, lim1;
    logic tick0;

    always_comb begin
        lim0   = (CNT_W'(1) << ratio0_i) - CNT_W'(1);
        lim1   = (CNT_W'(1) << ratio1_i) - CNT_W'(1);
        tick0  = run_i && (r_q.cnt0 == lim0);
        tick_o = tick0 && (r_q.cnt1 == lim1);
        r_d    = r_q;
        if (!run_i) begin
            r_d = '0;
        end else begin
            r_d.cnt0 = tick0 ? '0 : r_q.cnt0 + CNT_W'(1);
            if (tick0) r_d.cnt1 = tick_o ? '0 : r_q.cnt1 + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/te_tx_gate.sv
module te_tx_gate
    import te_gate_pkg::*;
#(
    parameter int unsigned P_RATIO_W = te_gate_pkg::RATIO_W,
    parameter int unsigned P_TTEW_W  = te_gate_pkg::TTEW_W,
    parameter int unsigned P_LEN_W   = te_gate_pkg::LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 te_i,
    input  logic                 cmd_valid_i,
    output logic                 cmd_ready_o,
    input  logic [1:0]           cmd_sync_i,
    input  logic [P_LEN_W-1:0]   cmd_len_i,
    input  logic [P_RATIO_W-1:0] ratio0_i,
    input  logic [P_RATIO_W-1:0] ratio1_i,
    input  logic [P_TTEW_W-1:0]  ttew_i,
    output logic                 go_o,
    output logic [P_LEN_W-1:0]   go_len_o
);
    typedef struct packed {
        gate_state_e            state;
        sync_mode_e             mode;
        logic [P_RATIO_W-1:0]   r0;
        logic [P_RATIO_W-1:0]   r1;
        logic [P_TTEW_W-1:0]    left;
        logic [P_LEN_W-1:0]     len;
    } gate_t;

    gate_t r_d, r_q;
    logic rise, fall, tick, hit, accept;

    te_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .te_i   (te_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    te_tick_gen #(.RATIO_W(P_RATIO_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (r_q.state == ST_DELAY),
        .ratio0_i (r_q.r0),
        .ratio1_i (r_q.r1),
        .tick_o   (tick)
    );

    always_comb begin
        r_d    = r_q;
        accept = cmd_valid_i && (r_q.state == ST_IDLE);
        hit    = ((r_q.mode == SYNC_RISE) && rise) ||
                 ((r_q.mode == SYNC_FALL) && fall);
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.mode = sync_mode_e'(cmd_sync_i);
                    r_d.r0   = ratio0_i;
                    r_d.r1   = ratio1_i;
                    r_d.left = ttew_i;
                    r_d.len  = cmd_len_i;
                    if (cmd_sync_i == SYNC_RISE || cmd_sync_i == SYNC_FALL)
                        r_d.state = ST_EDGE;
                    else
                        r_d.state = ST_FIRE;
                end
            end
            ST_EDGE: begin
                if (hit) r_d.state = (r_q.left == '0) ? ST_FIRE : ST_DELAY;
            end
            ST_DELAY: begin
                if (tick) begin
                    if (r_q.left == P_TTEW_W'(1)) r_d.state = ST_FIRE;
                    else r_d.left = r_q.left - P_TTEW_W'(1);
                end
            end
            ST_FIRE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.mode  <= SYNC_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready_o = (r_q.state == ST_IDLE);
    assign go_o        = (r_q.state == ST_FIRE);
    assign go_len_o    = r_q.len;
endmodule

// File: rtl/te_tx_gate_chk.sv
module te_tx_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_i,
    input logic       cmd_ready_o,
    input logic [1:0] cmd_sync_i,
    input logic       go_o
);
    // R9
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !go_o);

    // R10
    go_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> !cmd_ready_o);

    // R2
    nosync_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o && cmd_sync_i == 2'd0) |=> go_o);

    // R3
    rsvd_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o && cmd_sync_i == 2'd3) |=> go_o);

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o && (cmd_sync_i == 2'd1 || cmd_sync_i == 2'd2))
        |=> (!go_o && !cmd_ready_o));

    // R9
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> cmd_ready_o);
endmodule

bind te_tx_gate te_tx_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_sync_i  (cmd_sync_i),
    .go_o        (go_o)
);

// File: tb/te_tx_gate_bench.sv
module te_tx_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_i = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic        cmd_ready_o;
    logic [1:0]  cmd_sync_i = '0;
    logic [18:0] cmd_len_i = '0;
    logic [3:0]  ratio0_i = '0;
    logic [3:0]  ratio1_i = '0;
    logic [15:0] ttew_i = '0;
    logic        go_o;
    logic [18:0] go_len_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    te_tx_gate u_te_tx_gate (
        .clk(clk), .rst_n(rst_n), .te_i(te_i),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_sync_i(cmd_sync_i), .cmd_len_i(cmd_len_i),
        .ratio0_i(ratio0_i), .ratio1_i(ratio1_i), .ttew_i(ttew_i),
        .go_o(go_o), .go_len_o(go_len_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_latency(input int r0, input int r1, input int tw);
        return 3 + tw * (1 << (r0 + r1));
    endfunction

    // mode: sync code; decoy: put TE at the target level before acceptance
    // and make a wrong-direction transition before the real one
    task automatic do_cmd(input logic [1:0] mode, input logic [18:0] len,
                          input int r0, input int r1, input int tw,
                          input bit decoy, input bit mess);
        bit synced = (mode == 2'd1) || (mode == 2'd2);
        logic tgt = (mode == 2'd1);
        int cnt = 0;
        @(negedge clk);
        if (synced) te_i = decoy ? tgt : ~tgt;
        repeat (4) @(negedge clk);
        cmd_valid_i = 1'b1; cmd_sync_i = mode; cmd_len_i = len;
        ratio0_i = 4'(r0); ratio1_i = 4'(r1); ttew_i = 16'(tw);
        chk(cmd_ready_o == 1'b1, "R10 ready idle", cmd_ready_o, 1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        if (mess) begin
            ratio0_i = 4'($urandom_range(0, 3));
            ratio1_i = 4'($urandom_range(0, 3));
            ttew_i = 16'($urandom_range(1, 30));
        end
        if (!synced) begin
            chk(go_o == 1'b1, (mode == 2'd3) ? "R3 reserved fires" : "R2 nosync fires", go_o, 1);
            chk(go_len_o == len, "R9 go_len", go_len_o, len);
        end else begin
            cmd_valid_i = 1'b1;
            for (int i = 0; i < 6; i++) begin
                chk(go_o == 1'b0 && cmd_ready_o == 1'b0, "R10 held", {go_o, cmd_ready_o}, 0);
                @(negedge clk);
            end
            cmd_valid_i = 1'b0;
            if (decoy) begin
                te_i = ~tgt;
                for (int i = 0; i < 8; i++) begin
                    @(negedge clk);
                    chk(go_o == 1'b0, (mode == 2'd1) ? "R4 wrong edge" : "R5 wrong edge", go_o, 0);
                end
                chk(go_o == 1'b0, "R6 early level", go_o, 0);
            end
            te_i = tgt;
            while (cnt < 20000) begin
                @(posedge clk);
                cnt++;
                @(negedge clk);
                if (go_o) break;
            end
            chk(cnt == exp_latency(r0, r1, tw),
                (tw == 0) ? "R8 zero delay" : (mess ? "R11 latched" : "R7 latency"),
                cnt, exp_latency(r0, r1, tw));
            chk(go_len_o == len, "R9 go_len", go_len_o, len);
        end
        @(negedge clk);
        chk(go_o == 1'b0, "R9 single pulse", go_o, 0);
        chk(cmd_ready_o == 1'b1, "R9 ready back", cmd_ready_o, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(go_o == 1'b0, "R1 reset go", go_o, 0);
        chk(cmd_ready_o == 1'b1, "R1 reset ready", cmd_ready_o, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(go_o == 1'b0 && cmd_ready_o == 1'b1, "R1 after reset", {go_o, cmd_ready_o}, 1);

        do_cmd(2'd0, 19'd17, 0, 0, 5, 0, 0);
        do_cmd(2'd3, 19'd99, 2, 2, 9, 0, 0);
        do_cmd(2'd1, 19'h40000, 0, 0, 0, 0, 0);
        do_cmd(2'd2, 19'd1, 0, 0, 0, 0, 0);
        do_cmd(2'd1, 19'd300, 1, 2, 3, 1, 0);
        do_cmd(2'd2, 19'd301, 2, 1, 4, 1, 0);
        do_cmd(2'd1, 19'd7, 0, 0, 1, 0, 0);
        do_cmd(2'd2, 19'd8, 3, 3, 2, 0, 1);
        do_cmd(2'd1, 19'd9, 1, 0, 5, 1, 1);

        for (int k = 0; k < 30; k++) begin
            do_cmd(2'($urandom_range(0, 3)), 19'($urandom_range(1, 262144)),
                   $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 12), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)));
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (190000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule